// File: doc/BRIEF.md
# Multi-Line Serial Flash Read Sequencer

This block is the master side of a serial flash read. A control client presents an opcode, a 24-bit start address, a byte count, a lane mode and a dummy-clock count, then pulses `go`. The sequencer lowers chip select and sends the opcode on one line. It sends the address on one, two or four lines as the mode selects. It then runs the programmed number of idle dummy clocks with every output enable released, so the flash can take over the bus. Finally it collects read data on two or four lines. Chip select rises after the last byte.

The serial clock runs at half the system clock and idles low. Outputs change while SCLK is low and both sides sample on the rising edge. Each received byte enters a two-entry buffer and leaves on a valid/ready byte stream. If the consumer stops accepting and both entries are occupied, the sequencer holds SCLK low at the next byte boundary until space opens. No data is lost.

Top module: `flash_read_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, `sio_oe` is 0, `rd_valid` is 0 and `busy` is 0.
- R2: The opcode goes out first, 8 bits MSB first on `sio_out[0]` only, with `sio_oe` = 4'b0001. SCLK idles low and each SCLK high phase lasts exactly one system clock.
- R3: The 24-bit address follows MSB first. Mode code 0 and code 3 use one line (`sio_out[0]`, `sio_oe` = 4'b0001). Code 1 uses two lines: `sio_out[1]` carries the higher bit of each pair and `sio_oe` = 4'b0011. Code 2 uses four lines: `sio_out[3]` carries the highest bit of each nibble and `sio_oe` = 4'b1111.
- R4: Read data is sampled MSB first on each SCLK rise. Codes 0 and 1 read two lines, with bits 7,5,3,1 on `sio_in[1]` and bits 6,4,2,0 on `sio_in[0]`. Codes 2 and 3 read four lines, with `sio_in[3]` carrying bits 7 and 3, `sio_in[2]` bits 6 and 2, `sio_in[1]` bits 5 and 1, and `sio_in[0]` bits 4 and 0.
- R5: Exactly `cmd_dummy` (0 to 15) SCLK pulses separate the last address pulse from the first data pulse. `sio_oe` is 0 from the end of the address through the end of the transaction.
- R6: A transaction returns exactly `cmd_len_m1`+1 bytes (1 to 65536). After the last byte it raises `spi_cs_n` with `spi_sclk` low, and `busy` then falls.
- R7: Bytes leave in arrival order on `rd_data` with `rd_valid`. A byte moves when `rd_valid` and `rd_ready` are both 1. While `rd_ready` is 0, `rd_data` holds its value.
- R8: With two bytes waiting and `rd_ready` low, SCLK stays low at the start of the next byte and `spi_cs_n` stays low. Transfer resumes without loss once bytes are taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse, taken only while idle |
| cmd_op | input | 8 | Read opcode |
| cmd_addr | input | 24 | Start address |
| cmd_len_m1 | input | 16 | Byte count minus one |
| cmd_mode | input | 2 | Lane mode: 0 dual data, 1 dual address+data, 2 quad address+data, 3 quad data |
| cmd_dummy | input | 4 | Dummy SCLK pulses after the address |
| busy | output | 1 | Transaction in progress |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| sio_out | output | 4 | Values driven on the four data lines |
| sio_oe | output | 4 | Per-line output enables |
| sio_in | input | 4 | Values read from the four data lines |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | Received byte available |
| rd_ready | input | 1 | Consumer accepts the byte |

## Verification
A beat counter off by one shows within the same transaction as a wrong count of SCLK rises before data. It also shows as an address or opcode that a bus-side observer reassembles wrongly, or as a shifted byte at `rd_data`. A stuck phase state shows as a missing SCLK toggle inside two system clocks, or as an output enable still set during a dummy or data pulse. Buffer mistakes show as a repeated, dropped or reordered byte on the stream, or as SCLK still running after two unaccepted bytes.

// File: rtl/flrd_pkg.sv
package flrd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA, ST_END
  } seq_st_t;

  // log2 of the number of active lines
  typedef enum logic [1:0] {
    LW_ONE  = 2'd0,
    LW_TWO  = 2'd1,
    LW_FOUR = 2'd2
  } lane_w_t;

  function automatic lane_w_t addr_width(input logic [1:0] mode);
    case (mode)
      2'd1:    return LW_TWO;
      2'd2:    return LW_FOUR;
      default: return LW_ONE;
    endcase
  endfunction

  function automatic lane_w_t data_width(input logic [1:0] mode);
    return mode[1] ? LW_FOUR : LW_TWO;
  endfunction

  function automatic logic [3:0] lane_mask(input lane_w_t w);
    case (w)
      LW_TWO:  return 4'h3;
      LW_FOUR: return 4'hF;
      default: return 4'h1;
    endcase
  endfunction

endpackage

// File: rtl/flrd_lanes.sv
module flrd_lanes
  import flrd_pkg::*;
#(
  parameter int SH_W = 24
) (
  input  logic [SH_W-1:0] tx_sh,
  input  lane_w_t         tx_w,
  input  lane_w_t         rx_w,
  input  logic [3:0]      sio_in,
  input  logic [7:0]      rx_cur,
  output logic [3:0]      tx_lanes,
  output logic [7:0]      rx_next
);

  // Highest pending bit goes to the highest active line.
  always_comb begin
    case (tx_w)
      LW_TWO:  tx_lanes = {2'b00, tx_sh[SH_W-1], tx_sh[SH_W-2]};
      LW_FOUR: tx_lanes = tx_sh[SH_W-1 -: 4];
      default: tx_lanes = {3'b000, tx_sh[SH_W-1]};
    endcase
  end

  always_comb begin
    case (rx_w)
      LW_TWO:  rx_next = {rx_cur[5:0], sio_in[1:0]};
      LW_FOUR: rx_next = {rx_cur[3:0], sio_in};
      default: rx_next = {rx_cur[6:0], sio_in[1]};
    endcase
  end

endmodule

// File: rtl/flrd_skid.sv
module flrd_skid #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);

  logic [W-1:0] mem [2];
  logic         wp, rp;
  logic [1:0]   cnt;
  logic         pop;

  assign pop       = out_valid && out_ready;
  assign out_valid = (cnt != 2'd0);
  assign full      = (cnt == 2'd2);
  assign out_data  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= 1'b0;
      rp  <= 1'b0;
      cnt <= 2'd0;
    end else begin
      if (push) wp <= ~wp;
      if (pop)  rp <= ~rp;
      cnt <= cnt + 2'(push) - 2'(pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    full |-> !push); // R8

  AST_HOLD_WHILE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7

endmodule

// File: rtl/flash_read_seq.sv
module flash_read_seq
  import flrd_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int CNT_W   = 16,
  parameter int DUMMY_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic [7:0]         cmd_op,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [CNT_W-1:0]   cmd_len_m1,
  input  logic [1:0]         cmd_mode,
  input  logic [DUMMY_W-1:0] cmd_dummy,
  output logic               busy,
  output logic               spi_sclk,
  output logic               spi_cs_n,
  output logic [3:0]         sio_out,
  output logic [3:0]         sio_oe,
  input  logic [3:0]         sio_in,
  output logic [7:0]         rd_data,
  output logic               rd_valid,
  input  logic               rd_ready
);

  localparam int BEAT_W = ($clog2(ADDR_W) > DUMMY_W) ? $clog2(ADDR_W) : DUMMY_W;
  localparam logic [BEAT_W-1:0] ONE      = BEAT_W'(1);
  localparam logic [BEAT_W-1:0] CMD_LAST = BEAT_W'(7);

  seq_st_t              st, n_st;
  logic                 half, n_half;
  logic [BEAT_W-1:0]    beat, n_beat;
  logic [CNT_W-1:0]     bytes, n_bytes;
  logic [ADDR_W-1:0]    sh, n_sh, sh_adv, addr_q;
  lane_w_t              lw, n_lw, alw, dlw;
  logic [7:0]           rx, n_rx, rx_gather;
  logic                 n_sclk, n_csn;
  logic [3:0]           n_oe, tx_lanes;
  logic [1:0]           mode_q;
  logic [DUMMY_W-1:0]   dummy_q;
  logic [BEAT_W-1:0]    a_last, byte_last;
  logic                 push, skid_full, stall;

  assign alw  = addr_width(mode_q);
  assign dlw  = data_width(mode_q);
  assign busy = (st != ST_IDLE);

  always_comb begin
    case (alw)
      LW_TWO:  a_last = BEAT_W'(ADDR_W / 2 - 1);
      LW_FOUR: a_last = BEAT_W'(ADDR_W / 4 - 1);
      default: a_last = BEAT_W'(ADDR_W - 1);
    endcase
    byte_last = (dlw == LW_FOUR) ? BEAT_W'(1) : BEAT_W'(3);
    case (lw)
      LW_TWO:  sh_adv = sh << 2;
      LW_FOUR: sh_adv = sh << 4;
      default: sh_adv = sh << 1;
    endcase
  end

  // Hold SCLK low at a byte boundary while the buffer cannot take another byte.
  assign stall = (st == ST_DATA) && (beat == byte_last) && skid_full;

  always_comb begin
    n_st = st; n_half = half; n_beat = beat; n_bytes = bytes;
    n_sh = sh; n_lw = lw; n_rx = rx;
    n_sclk = spi_sclk; n_csn = spi_cs_n; n_oe = sio_oe;
    push = 1'b0;
    case (st)
      ST_IDLE: begin
        if (go) begin
          n_st    = ST_CMD;
          n_csn   = 1'b0;
          n_half  = 1'b0;
          n_sh    = {cmd_op, {(ADDR_W-8){1'b0}}};
          n_lw    = LW_ONE;
          n_beat  = CMD_LAST;
          n_oe    = 4'h1;
          n_bytes = cmd_len_m1;
        end
      end
      ST_END: n_st = ST_IDLE;
      default: begin
        if (!half) begin
          if (!stall) begin
            n_sclk = 1'b1;
            n_half = 1'b1;
            if (st == ST_DATA) begin
              n_rx = rx_gather;
              push = (beat == '0);
            end
          end
        end else begin
          n_sclk = 1'b0;
          n_half = 1'b0;
          if (beat != '0) begin
            n_beat = beat - ONE;
            if (st == ST_CMD || st == ST_ADDR) n_sh = sh_adv;
          end else begin
            case (st)
              ST_CMD: begin
                n_st   = ST_ADDR;
                n_sh   = addr_q;
                n_lw   = alw;
                n_beat = a_last;
                n_oe   = lane_mask(alw);
              end
              ST_ADDR: begin
                n_oe = 4'h0;
                if (dummy_q != '0) begin
                  n_st   = ST_DUMMY;
                  n_beat = BEAT_W'(dummy_q) - ONE;
                end else begin
                  n_st   = ST_DATA;
                  n_lw   = dlw;
                  n_beat = byte_last;
                end
              end
              ST_DUMMY: begin
                n_st   = ST_DATA;
                n_lw   = dlw;
                n_beat = byte_last;
              end
              default: begin
                if (bytes == '0) begin
                  n_st  = ST_END;
                  n_csn = 1'b1;
                end else begin
                  n_bytes = bytes - CNT_W'(1);
                  n_beat  = byte_last;
                end
              end
            endcase
          end
        end
      end
    endcase
  end

  flrd_lanes #(.SH_W(ADDR_W)) u_lanes (
    .tx_sh    (n_sh),
    .tx_w     (n_lw),
    .rx_w     (lw),
    .sio_in   (sio_in),
    .rx_cur   (rx),
    .tx_lanes (tx_lanes),
    .rx_next  (rx_gather)
  );

  flrd_skid #(.W(8)) u_skid (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .din       (rx_gather),
    .full      (skid_full),
    .out_valid (rd_valid),
    .out_data  (rd_data),
    .out_ready (rd_ready)
  );

  always_ff @(posedge clk) begin
    if (st == ST_IDLE && go) begin
      addr_q  <= cmd_addr;
      mode_q  <= cmd_mode;
      dummy_q <= cmd_dummy;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      half     <= 1'b0;
      beat     <= '0;
      bytes    <= '0;
      sh       <= '0;
      lw       <= LW_ONE;
      rx       <= '0;
      spi_sclk <= 1'b0;
      spi_cs_n <= 1'b1;
      sio_oe   <= 4'h0;
      sio_out  <= 4'h0;
    end else begin
      st       <= n_st;
      half     <= n_half;
      beat     <= n_beat;
      bytes    <= n_bytes;
      sh       <= n_sh;
      lw       <= n_lw;
      rx       <= n_rx;
      spi_sclk <= n_sclk;
      spi_cs_n <= n_csn;
      sio_oe   <= n_oe;
      sio_out  <= tx_lanes & n_oe;
    end
  end

  AST_DESELECT_CLOCK_IDLE: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk); // R6

  AST_OPCODE_ONE_LINE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CMD) |-> (sio_oe == 4'h1)); // R2

  AST_SHORT_HIGH_PHASE: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_sclk) |=> $fell(spi_sclk)); // R2

  AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DUMMY || st == ST_DATA) |-> (sio_oe == 4'h0)); // R5

  AST_STALL_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
    (skid_full && !rd_ready) |=> !$rose(spi_sclk)); // R8

endmodule

// File: tb/flash_read_seq_bench.sv
module flash_read_seq_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        go = 1'b0;
  logic [7:0]  cmd_op = '0;
  logic [23:0] cmd_addr = '0;
  logic [15:0] cmd_len_m1 = '0;
  logic [1:0]  cmd_mode = '0;
  logic [3:0]  cmd_dummy = '0;
  logic        busy, spi_sclk, spi_cs_n, rd_valid;
  logic [3:0]  sio_out, sio_oe;
  logic [3:0]  sio_in = '0;
  logic [7:0]  rd_data;
  logic        rd_ready = 1'b0;

  always #10 clk = ~clk;

  flash_read_seq u_flash_read_seq (
    .clk(clk), .rst(rst), .go(go), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_len_m1(cmd_len_m1), .cmd_mode(cmd_mode), .cmd_dummy(cmd_dummy),
    .busy(busy), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .sio_out(sio_out),
    .sio_oe(sio_oe), .sio_in(sio_in), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready)
  );

  int checks = 0;
  int fails  = 0;

  // configuration seen by the flash model and the consumer
  logic [23:0] cfg_addr = '0;
  int cfg_ab = 1, cfg_db = 2, cfg_dummy = 0, cfg_ready_mode = 0;
  bit hold_low = 1'b0;

  // observations made by the monitor
  int idx = 0, oe_bad_cmd = 0, oe_bad_addr = 0, oe_bad_late = 0, got_n = 0, byte_bad = 0;
  logic [7:0]  cap_cmd = '0;
  logic [23:0] cap_addr = '0;
  logic sclk_prev = 1'b0, cs_prev = 1'b1, tog = 1'b0;

  function automatic logic [7:0] exp_byte(input logic [23:0] a, input int k);
    return a[7:0] + 8'(k * 29) + 8'h3C;
  endfunction

  function automatic logic [3:0] mask_of(input int w);
    return (w == 1) ? 4'h1 : (w == 2) ? 4'h3 : 4'hF;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Flash model and byte consumer, evaluated away from the active edge.
  always @(negedge clk) begin
    if (rst) begin
      rd_ready = 1'b0;
    end else begin
      automatic int abeats = 24 / cfg_ab;
      automatic int pre    = 8 + abeats + cfg_dummy;
      automatic int bpb    = 8 / cfg_db;
      automatic bit r;
      if (cs_prev && !spi_cs_n) begin
        idx = 0; cap_cmd = '0; cap_addr = '0; oe_bad_cmd = 0; oe_bad_addr = 0;
        oe_bad_late = 0; got_n = 0; byte_bad = 0; sio_in = '0;
      end
      if (!sclk_prev && spi_sclk && !spi_cs_n) begin
        if (idx < 8) begin
          cap_cmd = {cap_cmd[6:0], sio_out[0]};
          if (sio_oe != 4'h1) oe_bad_cmd++;
        end else if (idx < 8 + abeats) begin
          case (cfg_ab)
            1:       cap_addr = {cap_addr[22:0], sio_out[0]};
            2:       cap_addr = {cap_addr[21:0], sio_out[1:0]};
            default: cap_addr = {cap_addr[19:0], sio_out};
          endcase
          if (sio_oe != mask_of(cfg_ab)) oe_bad_addr++;
        end else if (sio_oe != 4'h0) begin
          oe_bad_late++;
        end
        idx++;
      end
      if (sclk_prev && !spi_sclk && !spi_cs_n && idx >= pre) begin
        automatic int d = idx - pre;
        automatic logic [7:0] b = exp_byte(cfg_addr, d / bpb);
        automatic int p = d % bpb;
        if (cfg_db == 2) sio_in = {2'b00, 2'(b >> (6 - 2 * p))};
        else             sio_in = 4'(b >> (4 - 4 * p));
      end
      tog = ~tog;
      case (cfg_ready_mode)
        0:       r = 1'b1;
        1:       r = tog;
        default: r = !hold_low;
      endcase
      rd_ready = r;
      if (r && rd_valid) begin
        if (rd_data != exp_byte(cfg_addr, got_n)) byte_bad++;
        got_n++;
      end
      sclk_prev = spi_sclk;
      cs_prev   = spi_cs_n;
    end
  end

  task automatic launch(input logic [7:0] c, input logic [23:0] a, input logic [1:0] m,
                        input int dm, input int n, input int rm);
    @(posedge clk); #1;
    cfg_addr = a;
    cfg_ab = (m == 2'd1) ? 2 : (m == 2'd2) ? 4 : 1;
    cfg_db = m[1] ? 4 : 2;
    cfg_dummy = dm;
    cfg_ready_mode = rm;
    cmd_op = c; cmd_addr = a; cmd_mode = m; cmd_dummy = 4'(dm);
    cmd_len_m1 = 16'(n - 1);
    go = 1'b1;
    @(posedge clk); #1;
    go = 1'b0;
  endtask

  task automatic finish_checks(input logic [7:0] c, input logic [23:0] a, input int n);
    int t = 0;
    int exp_rises;
    while ((busy || got_n < n) && t < 20000) begin
      @(negedge clk); t++;
    end
    @(negedge clk);
    exp_rises = 8 + 24 / cfg_ab + cfg_dummy + n * (8 / cfg_db);
    chk(t < 20000, "R6 transaction completes", t, 0);
    chk(cap_cmd == c, "R2 opcode on one line", cap_cmd, c);
    chk(oe_bad_cmd == 0, "R2 opcode enables", oe_bad_cmd, 0);
    chk(cap_addr == a, "R3 address lanes", cap_addr, a);
    chk(oe_bad_addr == 0, "R3 address enables", oe_bad_addr, 0);
    chk(oe_bad_late == 0, "R5 bus released", oe_bad_late, 0);
    chk(idx == exp_rises, "R5 clock pulse total", idx, exp_rises);
    chk(got_n == n, "R6 byte count", got_n, n);
    chk(byte_bad == 0, "R4 data lane mapping", byte_bad, 0);
    chk(spi_cs_n && !spi_sclk && !busy, "R6 end state", {spi_cs_n, spi_sclk, busy}, 3'b100);
  endtask

  task automatic run_xfer(input logic [7:0] c, input logic [23:0] a, input logic [1:0] m,
                          input int dm, input int n, input int rm);
    launch(c, a, m, dm, n, rm);
    finish_checks(c, a, n);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(spi_cs_n == 1'b1, "R1 select idle", spi_cs_n, 1);
    chk(spi_sclk == 1'b0, "R1 clock idle", spi_sclk, 0);
    chk(sio_oe == 4'h0, "R1 enables off", sio_oe, 0);
    chk(!rd_valid && !busy, "R1 stream and busy", {rd_valid, busy}, 0);
  endtask

  task automatic test_stall();
    int r1;
    hold_low = 1'b1;
    launch(8'h6B, 24'h00A5C3, 2'd3, 0, 4, 2);
    repeat (300) @(negedge clk);
    r1 = idx;
    chk(r1 == 36, "R8 clock stops after two bytes", r1, 36);
    chk(rd_valid && !spi_cs_n, "R8 select held during stall", {rd_valid, spi_cs_n}, 2'b10);
    chk(rd_data == exp_byte(24'h00A5C3, 0), "R7 first byte held", rd_data, exp_byte(24'h00A5C3, 0));
    repeat (50) @(negedge clk);
    chk(idx == r1 && !spi_sclk, "R8 clock frozen", idx, r1);
    chk(rd_data == exp_byte(24'h00A5C3, 0), "R7 data stable while blocked", rd_data,
        exp_byte(24'h00A5C3, 0));
    @(posedge clk); #1;
    hold_low = 1'b0;
    finish_checks(8'h6B, 24'h00A5C3, 4);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    test_reset();
    run_xfer(8'h3B, 24'h12A4F0, 2'd0, 8, 3, 0);   // dual data, address on one line
    run_xfer(8'hBB, 24'h9C3E17, 2'd1, 4, 2, 1);   // dual address and data, ready toggles
    run_xfer(8'hEB, 24'h5A0F81, 2'd2, 6, 5, 0);   // quad address and data
    run_xfer(8'h6B, 24'hF0E1D2, 2'd3, 8, 1, 0);   // quad data, single byte
    run_xfer(8'hEB, 24'h000077, 2'd2, 0, 300, 1); // no dummy clocks, long read
    test_stall();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule